// File: doc/BRIEF.md
# Multi-Mode Serial Pattern Detector

The block watches a one-bit serial stream, qualified by a valid strobe, and raises a one-cycle detect flag according to one of four selectable rules. The first rule pulses on every n-th 1. The second flags whenever the running number of 1s is a multiple of three. The third fires at the end of the sequence 0-1-1. The fourth fires at the end of 1-0-1-0, with overlapping matches counted.

The four rule engines run side by side, and a registered multiplexer picks the flag of the selected rule. Only cycles with the strobe high move any engine. A change of the mode input clears every engine, so a newly selected rule always starts from a clean history. The n-th-one distance comes from an input port whose width is a parameter.

Top module: `seqdet_top`

## Requirements
- R1: While `rst_n` is low, `detect` is 0, every engine returns to its initial state and the remembered mode becomes 00.
- R2: `mode_sel` encodes the rule: 00 n-th one, 01 ones-count divisible by three, 10 pattern 011, 11 pattern 1010.
- R3: In mode 00 a flag is produced on an accepted 1 that makes the number of 1s since the last clear a multiple of `nth_n`. A value of `nth_n` of 0 or 1 flags every accepted 1.
- R4: In mode 00 an accepted 0 produces no flag and leaves the count of 1s unchanged.
- R5: In mode 01 every accepted bit after which the number of 1s since the last clear is a multiple of three produces a flag. This includes 0 bits taken while that number is a multiple of three.
- R6: In mode 10 an accepted bit produces a flag when the last three bits accepted since the last clear, oldest first, are 0, 1, 1.
- R7: In mode 11 an accepted bit produces a flag when the last four bits accepted since the last clear, oldest first, are 1, 0, 1, 0. Matches may overlap, so the stream 1010 10 flags twice.
- R8: `detect` is registered. It is 1 only in the single cycle that follows the rising edge at which the completing bit was sampled.
- R9: A cycle with `bit_valid` low leaves every engine unchanged, and `detect` is 0 in the following cycle.
- R10: In any cycle where `mode_sel` differs from its value in the previous cycle, every engine is cleared, the bit offered in that cycle is discarded, and `detect` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_valid | input | 1 | Strobe that qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial data bit |
| mode_sel | input | 2 | Rule select (see R2) |
| nth_n | input | NTH_W | Distance in 1s for the n-th-one rule |
| detect | output | 1 | Registered one-cycle detection flag |

## Verification
The assertions assume that `nth_n` holds steady while the n-th-one rule is counting. A new distance is meaningful only after a reset or a mode change. They also assume that the inputs are never unknown at a sampling edge. The bench meets both conditions. It changes `nth_n` only while reset is held, and it drives every input at the falling edge from a pseudo-random sequence, with roughly one idle cycle in four. Mode changes are made on purpose while the strobe is high, so that the discarded bit of R10 is observed.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;
  typedef enum logic [1:0] {
    MODE_NTH   = 2'b00,
    MODE_DIV3  = 2'b01,
    MODE_P011  = 2'b10,
    MODE_P1010 = 2'b11
  } mode_e;
  localparam int unsigned NUM_MODES = 4;
endpackage

// File: rtl/seqdet_nth.sv
module seqdet_nth #(
  parameter int unsigned NW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          din,
  input  logic [NW-1:0] n_sel,
  output logic          hit
);
  logic [NW-1:0] cnt_q, cnt_d;
  logic [NW:0]   inc;
  logic          upd;

  always_comb begin
    inc   = {1'b0, cnt_q} + {{NW{1'b0}}, 1'b1};
    hit   = din && (inc >= {1'b0, n_sel});
    upd   = clr || (en && din);
    cnt_d = cnt_q;
    if (clr)             cnt_d = '0;
    else if (en && din)  cnt_d = hit ? '0 : inc[NW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (upd) cnt_q <= cnt_d;
  end

  assert_zero_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !din && !clr) |=> $stable(cnt_q));
  assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hit && !clr) |=> (cnt_q == '0));
endmodule

// File: rtl/seqdet_div3.sv
module seqdet_div3 (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic din,
  output logic hit
);
  logic [1:0] rem_q, rem_nxt, rem_d;
  logic       upd;

  always_comb begin
    rem_nxt = rem_q;
    if (din) rem_nxt = (rem_q == 2'd2) ? 2'd0 : rem_q + 2'd1;
    hit   = (rem_nxt == 2'd0);
    upd   = clr || en;
    rem_d = clr ? 2'd0 : rem_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rem_q <= 2'd0;
    else if (upd) rem_q <= rem_d;
  end

  assert_rem_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q != 2'd3);
endmodule

// File: rtl/seqdet_p011.sv
module seqdet_p011 (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic din,
  output logic hit
);
  typedef enum logic [1:0] {A0 = 2'b00, A1 = 2'b01, A2 = 2'b10, A3 = 2'b11} st_e;
  st_e st_q, st_nxt, st_d;
  logic upd;

  always_comb begin
    unique case (st_q)
      A0: st_nxt = din ? A0 : A1;
      A1: st_nxt = din ? A2 : A1;
      A2: st_nxt = din ? A3 : A1;
      A3: st_nxt = din ? A0 : A1;
      default: st_nxt = A0;
    endcase
    hit  = (st_nxt == A3);
    upd  = clr || en;
    st_d = clr ? A0 : st_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st_q <= A0;
    else if (upd) st_q <= st_d;
  end

  assert_final_from_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && st_q != A2) |=> (st_q != A3));
endmodule

// File: rtl/seqdet_p1010.sv
module seqdet_p1010 (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic din,
  output logic hit
);
  typedef enum logic [2:0] {
    B0 = 3'd0, B1 = 3'd1, B2 = 3'd2, B3 = 3'd3, B4 = 3'd4
  } st_e;
  st_e st_q, st_nxt, st_d;
  logic upd;

  always_comb begin
    unique case (st_q)
      B0: st_nxt = din ? B1 : B0;
      B1: st_nxt = din ? B1 : B2;
      B2: st_nxt = din ? B3 : B0;
      B3: st_nxt = din ? B1 : B4;
      B4: st_nxt = din ? B3 : B0;
      default: st_nxt = B0;
    endcase
    hit  = (st_nxt == B4);
    upd  = clr || en;
    st_d = clr ? B0 : st_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st_q <= B0;
    else if (upd) st_q <= st_d;
  end

  assert_state_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_q <= B4);
  assert_overlap_reentry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && st_q == B4 && din) |=> (st_q == B3));
endmodule

// File: rtl/seqdet_top.sv
module seqdet_top
  import seqdet_pkg::*;
#(
  parameter int unsigned NTH_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  input  logic             bit_in,
  input  logic [1:0]       mode_sel,
  input  logic [NTH_W-1:0] nth_n,
  output logic             detect
);
  logic [1:0]           mode_q;
  logic                 mode_chg, acc, det_d;
  logic [NUM_MODES-1:0] hits;

  always_comb begin
    mode_chg = (mode_sel != mode_q);
    acc      = bit_valid && !mode_chg;
  end

  seqdet_nth #(.NW(NTH_W)) u_nth (
    .clk(clk), .rst_n(rst_n), .clr(mode_chg), .en(acc), .din(bit_in),
    .n_sel(nth_n), .hit(hits[MODE_NTH])
  );
  seqdet_div3 u_div3 (
    .clk(clk), .rst_n(rst_n), .clr(mode_chg), .en(acc), .din(bit_in),
    .hit(hits[MODE_DIV3])
  );
  seqdet_p011 u_p011 (
    .clk(clk), .rst_n(rst_n), .clr(mode_chg), .en(acc), .din(bit_in),
    .hit(hits[MODE_P011])
  );
  seqdet_p1010 u_p1010 (
    .clk(clk), .rst_n(rst_n), .clr(mode_chg), .en(acc), .din(bit_in),
    .hit(hits[MODE_P1010])
  );

  always_comb det_d = acc && hits[mode_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_NTH;
      detect <= 1'b0;
    end else begin
      if (mode_chg) mode_q <= mode_sel;
      detect <= det_d;
    end
  end

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> !detect);
  assert_modechg_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != mode_q) |=> !detect);
  assert_zero_no_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !bit_in && mode_sel == MODE_P011) |=> !detect);
  assert_nth_zero_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !bit_in && mode_sel == MODE_NTH) |=> !detect);
endmodule

// File: tb/sim_seqdet_top.sv
`timescale 1ns/1ps
module sim_seqdet_top;
  localparam int unsigned NTH_W = 3;

  logic             clk = 1'b0;
  logic             rst_n, bit_valid, bit_in;
  logic [1:0]       mode_sel;
  logic [NTH_W-1:0] nth_n;
  logic             detect;

  int checks = 0;
  int errors = 0;
  int ones, nbits;
  logic [3:0] hist;
  logic [1:0] mprev;
  logic [15:0] lf = 16'hACE1;

  always #2 clk = ~clk;

  seqdet_top #(.NTH_W(NTH_W)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .mode_sel(mode_sel), .nth_n(nth_n), .detect(detect)
  );

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: detect=%0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic model_clear();
    ones = 0; nbits = 0; hist = 4'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bit_valid = 1'b0; bit_in = 1'b0; mode_sel = 2'b00;
    repeat (2) @(negedge clk);
    chk(detect, 1'b0, "R1");
    rst_n = 1'b1;
    model_clear();
    mprev = 2'b00;
  endtask

  // drive one cycle at the falling edge, check the flag one falling edge later
  task automatic step(input logic v, input logic b);
    logic  e;
    string req;
    int    n_i;
    e = 1'b0;
    n_i = int'(nth_n);
    if (mode_sel != mprev) begin
      model_clear();
      req = "R10";
    end else if (!v) begin
      req = "R9";
    end else begin
      nbits++;
      hist = {hist[2:0], b};
      if (b) ones++;
      case (mode_sel)
        2'b00: begin
          e = b && ((n_i <= 1) || (ones % n_i == 0));
          req = b ? "R2/R3" : "R4";
        end
        2'b01: begin e = (ones % 3 == 0); req = "R2/R5"; end
        2'b10: begin e = (nbits >= 3) && (hist[2:0] == 3'b011); req = "R2/R6"; end
        default: begin e = (nbits >= 4) && (hist == 4'b1010); req = "R2/R7"; end
      endcase
    end
    mprev = mode_sel;
    bit_valid = v; bit_in = b;
    @(negedge clk);
    chk(detect, e, req);
  endtask

  task automatic rand_run(input int len);
    for (int i = 0; i < len; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[1:0] != 2'b00, lf[5]);
    end
  endtask

  initial begin
    #800us;
    errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    nth_n = 3'd2;
    do_reset();

    // known stream, distance two: 1s at 2,5,6,7,9,10 -> flags at 5,7,10
    begin
      logic [10:0] s = 11'b00100111011;
      for (int i = 0; i < 11; i++) begin
        step(1'b1, s[10-i]);
        checks++;
        if (detect !== (i == 5 || i == 7 || i == 10)) begin
          errors++;
          $display("FAIL R3: pos %0d detect=%0b expected %0b", i, detect, (i == 5 || i == 7 || i == 10));
        end
      end
    end

    // registered single-cycle flag: hit then idle gives 0
    do_reset();
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    chk(detect, 1'b1, "R8");
    step(1'b0, 1'b1);
    chk(detect, 1'b0, "R8");

    // sweep every distance under reset
    for (int n = 0; n < 8; n++) begin
      nth_n = n[NTH_W-1:0];
      do_reset();
      rand_run(80);
    end

    // every rule, entered through a mode change carrying a valid 1 (R10)
    for (int m = 1; m < 4; m++) begin
      mode_sel = m[1:0];
      step(1'b1, 1'b1);
      rand_run(300);
    end
    for (int m = 0; m < 4; m++) begin
      mode_sel = m[1:0];
      step(1'b1, 1'b0);
      rand_run(150);
    end

    // overlapping 1010 stream: flags only at positions 16 and 18
    mode_sel = 2'b01;
    step(1'b0, 1'b0);
    mode_sel = 2'b11;
    step(1'b0, 1'b0);
    begin
      logic [25:0] s = 26'b00100111011001010101110001;
      for (int i = 0; i < 26; i++) begin
        step(1'b1, s[25-i]);
        checks++;
        if (detect !== (i == 16 || i == 18)) begin
          errors++;
          $display("FAIL R7: pos %0d detect=%0b expected %0b", i, detect, (i == 16 || i == 18));
        end
      end
    end

    // mid-pattern mode flip drops history: 1,0,1 then flip away and back, then 0
    step(1'b1, 1'b1); step(1'b1, 1'b0); step(1'b1, 1'b1);
    mode_sel = 2'b10; step(1'b0, 1'b0);
    mode_sel = 2'b11; step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    chk(detect, 1'b0, "R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule